// File: doc/BRIEF.md
# Boundary-scan test access port controller

This block is the serial test port of a chip. It follows the standard five-wire test access protocol. A mode input stepped on every test clock drives a sixteen-state controller through the data-scan and instruction-scan branches. A three-bit instruction then selects which internal register sits between the serial input and the serial output.

The block holds the instruction register, a one-bit pass-through register and a 32-bit identification register. The boundary-scan chain itself lives outside the block. The controller reaches it through capture, shift and update strobes and takes the chain's serial output back on `bsr_so`. Two mode outputs tell the pad ring what to do:
- `pins_from_scan` makes the pads drive from the chain's update latches.
- `outputs_off` forces every system output enable inactive.

Both the identification register and the instruction register leave least significant bit first. The serial output changes on the falling test clock edge. The serial output enable is high only while a register is being shifted.

Top module: `scan_port`

## Requirements
- R1: While `trst_n` is low the controller sits in its reset state, all outputs are 0, and the instruction becomes IDCODE (code 001). A data scan straight after reset therefore returns the identification word.
- R2: The controller follows the standard sixteen-state transition graph on `tms`, sampled on the rising edge of `tck`. Five consecutive clocks with `tms` high reach the reset state from any state, and that reset reloads IDCODE.
- R3: The identification word is laid out as follows: bit 0 is 1, bits 11:1 hold the manufacturer field (default 0x033), bits 27:12 hold the part field (default 0x04D7) and bits 31:28 hold the version field (default 0x1). It is captured in Capture-DR and shifted out least significant bit first.
- R4: Capture-IR loads 001 into the instruction shift register, so an instruction scan returns 1, 0, 0 on `tdo` in that order.
- R5: BYPASS (code 111) places the one-bit register in the path. It captures 0, then repeats `tdi` on `tdo` exactly one clock later.
- R6: The unused codes 101 and 110 select the one-bit register. They leave `pins_from_scan`, `outputs_off` and all chain strobes at 0.
- R7: EXTEST (code 000) selects the chain and sets `pins_from_scan`.
  - `bsr_capture`, `bsr_shift` and `bsr_update` are high in Capture-DR, Shift-DR and Update-DR respectively, and at most one is high at a time.
  - In Shift-DR, `tdo` carries `bsr_so`.
- R8: SAMPLE/PRELOAD (code 010) selects the chain with the same strobes as EXTEST, while `pins_from_scan` stays 0.
- R9: CLAMP (code 011) sets `pins_from_scan` and selects the one-bit register, so no chain strobe fires during a data scan.
- R10: HIGHZ (code 100) sets `outputs_off`, selects the one-bit register, and keeps `pins_from_scan` and the chain strobes at 0.
- R11: The active instruction changes only on the falling `tck` edge in Update-IR or in the reset state. Shifting a new code does not alter the mode outputs until Update-IR.
- R12: `tdo` and `tdo_oe` are registered on the falling `tck` edge. `tdo_oe` is 1 only in Shift-IR and Shift-DR, and `tdo` is 0 whenever `tdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, also the chain's serial input |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_oe | output | 1 | Enable for the `tdo` pad driver |
| bsr_capture | output | 1 | Chain capture strobe |
| bsr_shift | output | 1 | Chain shift strobe |
| bsr_update | output | 1 | Chain update strobe |
| pins_from_scan | output | 1 | Pads driven from chain update latches |
| outputs_off | output | 1 | Force all system output enables inactive |

## Verification
The bench targets the following corner cases:
- **Return to reset by mode input alone.** The bench walks the controller through the pause and exit states and then returns it to reset with `tms` only. A design with a wrong arc would desynchronise there and lose the identification word.
- **Falling-edge instruction update.** The bench shifts a new code while HIGHZ is active and checks that the mode outputs hold until Update-IR. A design that updated the instruction during the shift would glitch the pad modes.
- **Unused codes.** A wrong decode would fire chain strobes or pad modes under codes 101 and 110.
- **CLAMP and HIGHZ.** These must take the one-bit path. A design that routed them to the chain would show extra delay or strobes.
- **Bypass delay.** An off-by-one shift would show up as a misplaced bit in the bypass scan.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

  localparam int unsigned IR_W = 3;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_DR_SEL, TS_DR_CAP, TS_DR_SHIFT, TS_DR_EXIT1, TS_DR_PAUSE, TS_DR_EXIT2, TS_DR_UPD,
    TS_IR_SEL, TS_IR_CAP, TS_IR_SHIFT, TS_IR_EXIT1, TS_IR_PAUSE, TS_IR_EXIT2, TS_IR_UPD
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b010;
  localparam logic [IR_W-1:0] OP_CLAMP   = 3'b011;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  // value shifted into the instruction register during Capture-IR
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BSR} path_e;

  typedef struct packed {
    path_e path;
    logic  pins_from_scan;
    logic  outputs_off;
  } decode_t;

  // unused codes fall through to the one-bit path with no pad mode
  function automatic decode_t decode_op(logic [IR_W-1:0] op);
    decode_t d;
    d.path           = PATH_BYP;
    d.pins_from_scan = 1'b0;
    d.outputs_off    = 1'b0;
    case (op)
      OP_EXTEST: begin
        d.path           = PATH_BSR;
        d.pins_from_scan = 1'b1;
      end
      OP_SAMPLE: d.path = PATH_BSR;
      OP_IDCODE: d.path = PATH_ID;
      OP_CLAMP:  d.pins_from_scan = 1'b1;
      OP_HIGHZ:  d.outputs_off = 1'b1;
      default:   d.path = PATH_BYP;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/scan_port_rsync.sv
module scan_port_rsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/scan_port_fsm.sv
module scan_port_fsm
  import scan_port_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_d;

  always_comb begin
    state_d = state;
    case (state)
      TS_RESET:    state_d = tms ? TS_RESET    : TS_IDLE;
      TS_IDLE:     state_d = tms ? TS_DR_SEL   : TS_IDLE;
      TS_DR_SEL:   state_d = tms ? TS_IR_SEL   : TS_DR_CAP;
      TS_DR_CAP:   state_d = tms ? TS_DR_EXIT1 : TS_DR_SHIFT;
      TS_DR_SHIFT: state_d = tms ? TS_DR_EXIT1 : TS_DR_SHIFT;
      TS_DR_EXIT1: state_d = tms ? TS_DR_UPD   : TS_DR_PAUSE;
      TS_DR_PAUSE: state_d = tms ? TS_DR_EXIT2 : TS_DR_PAUSE;
      TS_DR_EXIT2: state_d = tms ? TS_DR_UPD   : TS_DR_SHIFT;
      TS_DR_UPD:   state_d = tms ? TS_DR_SEL   : TS_IDLE;
      TS_IR_SEL:   state_d = tms ? TS_RESET    : TS_IR_CAP;
      TS_IR_CAP:   state_d = tms ? TS_IR_EXIT1 : TS_IR_SHIFT;
      TS_IR_SHIFT: state_d = tms ? TS_IR_EXIT1 : TS_IR_SHIFT;
      TS_IR_EXIT1: state_d = tms ? TS_IR_UPD   : TS_IR_PAUSE;
      TS_IR_PAUSE: state_d = tms ? TS_IR_EXIT2 : TS_IR_PAUSE;
      TS_IR_EXIT2: state_d = tms ? TS_IR_UPD   : TS_IR_SHIFT;
      TS_IR_UPD:   state_d = tms ? TS_DR_SEL   : TS_IDLE;
      default:     state_d = TS_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= TS_RESET;
    else        state <= state_d;
  end

endmodule

// File: rtl/scan_port_ir.sv
module scan_port_ir
  import scan_port_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir_q,
  output logic [IR_W-1:0] ir_sr,
  output logic            ir_lsb
);

  logic [IR_W-1:0] sr_d;
  logic            sr_en;
  logic [IR_W-1:0] ir_d;
  logic            ir_en;

  // shift stage, rising edge
  always_comb begin
    sr_en = 1'b0;
    sr_d  = ir_sr;
    if (state == TS_IR_CAP) begin
      sr_en = 1'b1;
      sr_d  = IR_CAPTURE;
    end else if (state == TS_IR_SHIFT) begin
      sr_en = 1'b1;
      sr_d  = {tdi, ir_sr[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     ir_sr <= IR_CAPTURE;
    else if (sr_en) ir_sr <= sr_d;
  end

  // active instruction, falling edge
  always_comb begin
    ir_en = 1'b0;
    ir_d  = ir_q;
    if (state == TS_RESET) begin
      ir_en = 1'b1;
      ir_d  = OP_IDCODE;
    end else if (state == TS_IR_UPD) begin
      ir_en = 1'b1;
      ir_d  = ir_sr;
    end
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)     ir_q <= OP_IDCODE;
    else if (ir_en) ir_q <= ir_d;
  end

  assign ir_lsb = ir_sr[0];

endmodule

// File: rtl/scan_port_dr.sv
module scan_port_dr
  import scan_port_pkg::*;
#(
  parameter logic [10:0] MFR_ID  = 11'h033,
  parameter logic [15:0] PART_ID = 16'h04D7,
  parameter logic [3:0]  VERSION = 4'h1
) (
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tdi,
  input  tap_state_e state,
  input  path_e      path,
  output logic       id_lsb,
  output logic       byp_q
);

  localparam int unsigned ID_W = 1 + $bits(MFR_ID) + $bits(PART_ID) + $bits(VERSION);
  localparam logic [ID_W-1:0] ID_WORD = {VERSION, PART_ID, MFR_ID, 1'b1};

  logic [ID_W-1:0] id_q;
  logic [ID_W-1:0] id_d;
  logic            id_en;
  logic            byp_d;
  logic            byp_en;

  always_comb begin
    id_en  = 1'b0;
    id_d   = id_q;
    byp_en = 1'b0;
    byp_d  = byp_q;
    if (state == TS_DR_CAP) begin
      id_en  = 1'b1;
      id_d   = ID_WORD;
      byp_en = 1'b1;
      byp_d  = 1'b0;
    end else if (state == TS_DR_SHIFT) begin
      if (path == PATH_ID) begin
        id_en = 1'b1;
        id_d  = {tdi, id_q[ID_W-1:1]};
      end
      if (path == PATH_BYP) begin
        byp_en = 1'b1;
        byp_d  = tdi;
      end
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     id_q <= ID_WORD;
    else if (id_en) id_q <= id_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      byp_q <= 1'b0;
    else if (byp_en) byp_q <= byp_d;
  end

  assign id_lsb = id_q[0];

endmodule

// File: rtl/scan_port.sv
module scan_port
  import scan_port_pkg::*;
#(
  parameter logic [10:0] MFR_ID      = 11'h033,
  parameter logic [15:0] PART_ID     = 16'h04D7,
  parameter logic [3:0]  VERSION     = 4'h1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic bsr_so,
  output logic tdo,
  output logic tdo_oe,
  output logic bsr_capture,
  output logic bsr_shift,
  output logic bsr_update,
  output logic pins_from_scan,
  output logic outputs_off
);

  logic            rst_n;
  tap_state_e      state;
  logic [IR_W-1:0] ir_q;
  logic [IR_W-1:0] ir_sr;
  logic            ir_lsb;
  logic            id_lsb;
  logic            byp_q;
  decode_t         dec;
  logic            tdo_d;
  logic            oe_d;

  scan_port_rsync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk    (tck),
    .arst_n (trst_n),
    .rst_n  (rst_n)
  );

  scan_port_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  scan_port_ir u_ir (
    .tck    (tck),
    .rst_n  (rst_n),
    .tdi    (tdi),
    .state  (state),
    .ir_q   (ir_q),
    .ir_sr  (ir_sr),
    .ir_lsb (ir_lsb)
  );

  always_comb dec = decode_op(ir_q);

  scan_port_dr #(
    .MFR_ID  (MFR_ID),
    .PART_ID (PART_ID),
    .VERSION (VERSION)
  ) u_dr (
    .tck    (tck),
    .rst_n  (rst_n),
    .tdi    (tdi),
    .state  (state),
    .path   (dec.path),
    .id_lsb (id_lsb),
    .byp_q  (byp_q)
  );

  // serial output selection
  always_comb begin
    tdo_d = 1'b0;
    oe_d  = 1'b0;
    if (state == TS_IR_SHIFT) begin
      oe_d  = 1'b1;
      tdo_d = ir_lsb;
    end else if (state == TS_DR_SHIFT) begin
      oe_d = 1'b1;
      case (dec.path)
        PATH_ID:  tdo_d = id_lsb;
        PATH_BSR: tdo_d = bsr_so;
        default:  tdo_d = byp_q;
      endcase
    end
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_oe <= oe_d;
    end
  end

  assign bsr_capture    = (state == TS_DR_CAP)   && (dec.path == PATH_BSR);
  assign bsr_shift      = (state == TS_DR_SHIFT) && (dec.path == PATH_BSR);
  assign bsr_update     = (state == TS_DR_UPD)   && (dec.path == PATH_BSR);
  assign pins_from_scan = dec.pins_from_scan;
  assign outputs_off    = dec.outputs_off;

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
  import scan_port_pkg::*;
(
  input logic            tck,
  input logic            rst_n,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir_q,
  input logic [IR_W-1:0] ir_sr,
  input logic            tdo,
  input logic            tdo_oe,
  input logic            bsr_capture,
  input logic            bsr_shift,
  input logic            bsr_update,
  input logic            pins_from_scan,
  input logic            outputs_off
);

  // R12
  tdo_quiet_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !tdo_oe |-> !tdo);

  // R12
  tdo_oe_state_chk: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe == (state == TS_IR_SHIFT || state == TS_DR_SHIFT));

  // R7
  strobe_onehot_chk: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0({bsr_capture, bsr_shift, bsr_update}));

  // R10
  highz_quiet_chk: assert property (@(posedge tck) disable iff (!rst_n)
    outputs_off |-> !(bsr_capture || bsr_shift || bsr_update || pins_from_scan));

  // R4
  capture_ir_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state == TS_IR_CAP) |=> (ir_sr == IR_CAPTURE));

  // R11
  ir_update_chk: assert property (@(negedge tck) disable iff (!rst_n)
    (ir_q != $past(ir_q)) |-> ($past(state) == TS_IR_UPD || $past(state) == TS_RESET));

endmodule

bind scan_port scan_port_chk u_chk (
  .tck            (tck),
  .rst_n          (rst_n),
  .state          (state),
  .ir_q           (ir_q),
  .ir_sr          (ir_sr),
  .tdo            (tdo),
  .tdo_oe         (tdo_oe),
  .bsr_capture    (bsr_capture),
  .bsr_shift      (bsr_shift),
  .bsr_update     (bsr_update),
  .pins_from_scan (pins_from_scan),
  .outputs_off    (outputs_off)
);

// File: tb/sim_scan_port.sv
module sim_scan_port;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [10:0] MFR  = 11'h033;
  localparam logic [15:0] PART = 16'h04D7;
  localparam logic [3:0]  VER  = 4'h1;
  localparam logic [31:0] ID_EXP = {VER, PART, MFR, 1'b1};

  // bench-side state numbering
  localparam int RST = 0, IDL = 1, DSEL = 2, DCAP = 3, DSH = 4, DEX1 = 5, DPAU = 6, DEX2 = 7,
                 DUPD = 8, ISEL = 9, ICAP = 10, ISH = 11, IEX1 = 12, IPAU = 13, IEX2 = 14, IUPD = 15;

  logic tck = 1'b0;
  logic trst_n, tms, tdi, bsr_so;
  logic tdo, tdo_oe, bsr_capture, bsr_shift, bsr_update, pins_from_scan, outputs_off;

  always #2.5 tck = ~tck;

  scan_port u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bsr_so(bsr_so),
    .tdo(tdo), .tdo_oe(tdo_oe), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
    .bsr_update(bsr_update), .pins_from_scan(pins_from_scan), .outputs_off(outputs_off)
  );

  int checks = 0;
  int fails  = 0;
  int m_state, m_ir;
  bit m_irq[$];
  bit m_idq[$];
  bit m_byp, m_tdo, m_oe;
  logic [15:0] lfsr;
  bit seen_cap, seen_sh, seen_up;

  function automatic int nxt(int s, bit m);
    case (s)
      RST:  return m ? RST  : IDL;
      IDL:  return m ? DSEL : IDL;
      DSEL: return m ? ISEL : DCAP;
      DCAP: return m ? DEX1 : DSH;
      DSH:  return m ? DEX1 : DSH;
      DEX1: return m ? DUPD : DPAU;
      DPAU: return m ? DEX2 : DPAU;
      DEX2: return m ? DUPD : DSH;
      DUPD: return m ? DSEL : IDL;
      ISEL: return m ? RST  : ICAP;
      ICAP: return m ? IEX1 : ISH;
      ISH:  return m ? IEX1 : ISH;
      IEX1: return m ? IUPD : IPAU;
      IPAU: return m ? IEX2 : IPAU;
      IEX2: return m ? IUPD : ISH;
      default: return m ? DSEL : IDL;
    endcase
  endfunction

  // 2 = chain, 1 = identification, 0 = one-bit register
  function automatic int path_of(int op);
    if (op == 0 || op == 2) return 2;
    if (op == 1) return 1;
    return 0;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load_id;
    m_idq.delete();
    for (int i = 0; i < 32; i++) m_idq.push_back(ID_EXP[i]);
  endtask

  task automatic model_reset;
    m_state = RST;
    m_ir    = 1;
    m_irq   = {1'b1, 1'b0, 1'b0};
    load_id();
    m_byp = 0;
    m_tdo = 0;
    m_oe  = 0;
  endtask

  task automatic tick(input bit t, input bit d);
    bit so;
    int p;
    so   = lfsr[0];
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tms = t; tdi = d; bsr_so = so;
    @(posedge tck);
    p = path_of(m_ir);
    case (m_state)
      ISH:  begin void'(m_irq.pop_front()); m_irq.push_back(d); end
      ICAP: m_irq = {1'b1, 1'b0, 1'b0};
      DCAP: begin load_id(); m_byp = 0; end
      DSH: begin
        if (p == 1) begin void'(m_idq.pop_front()); m_idq.push_back(d); end
        else if (p == 0) m_byp = d;
      end
      default: ;
    endcase
    m_state = nxt(m_state, t);
    @(negedge tck);
    if (m_state == IUPD) m_ir = m_irq[0] + 2 * m_irq[1] + 4 * m_irq[2];
    else if (m_state == RST) m_ir = 1;
    p = path_of(m_ir);
    m_oe  = (m_state == ISH || m_state == DSH);
    m_tdo = 0;
    if (m_state == ISH) m_tdo = m_irq[0];
    if (m_state == DSH) m_tdo = (p == 1) ? m_idq[0] : (p == 0) ? m_byp : so;
    #1;
    chk("R12 tdo", tdo, m_tdo);
    chk("R2 tdo_oe", tdo_oe, m_oe);
    chk("R7 bsr_capture", bsr_capture, (p == 2 && m_state == DCAP));
    chk("R7 bsr_shift", bsr_shift, (p == 2 && m_state == DSH));
    chk("R7 bsr_update", bsr_update, (p == 2 && m_state == DUPD));
    chk("R9 pins_from_scan", pins_from_scan, (m_ir == 0 || m_ir == 3));
    chk("R10 outputs_off", outputs_off, (m_ir == 4));
    seen_cap |= bsr_capture;
    seen_sh  |= bsr_shift;
    seen_up  |= bsr_update;
  endtask

  // from Run-Test/Idle to Exit1-IR, shifting op and reading the captured bits
  task automatic shift_ir(input logic [2:0] op, output logic [2:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      tick(i == 2, op[i]);
    end
  endtask

  task automatic finish_ir;
    tick(1, 0); tick(0, 0);
  endtask

  task automatic load_ir(input logic [2:0] op);
    logic [2:0] c;
    shift_ir(op, c);
    finish_ir();
  endtask

  task automatic scan_dr(input logic [63:0] din, input int n, output logic [63:0] dout);
    seen_cap = 0; seen_sh = 0; seen_up = 0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    dout = '0;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      tick(i == n - 1, din[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [2:0]  c;
    trst_n = 0; tms = 1; tdi = 0; bsr_so = 0; lfsr = 16'hACE1;
    model_reset();
    repeat (3) @(negedge tck);
    #1;
    chk("R1 reset tdo", tdo, 0);
    chk("R1 reset tdo_oe", tdo_oe, 0);
    chk("R1 reset strobes", {bsr_capture, bsr_shift, bsr_update}, 0);
    chk("R1 reset modes", {pins_from_scan, outputs_off}, 0);
    trst_n = 1;
    repeat (5) tick(1, 0);
    tick(0, 0);

    scan_dr(64'h0, 32, d);
    chk("R1 id after reset", d[31:0], ID_EXP);
    chk("R3 marker bit", d[0], 1);
    chk("R3 manufacturer", d[11:1], MFR);
    chk("R3 part", d[27:12], PART);
    chk("R3 version", d[31:28], VER);

    shift_ir(3'b111, c);
    chk("R4 captured ir", c, 3'b001);
    finish_ir();
    scan_dr(64'hA5, 8, d);
    chk("R5 bypass delay", d[7:0], 8'h4A);

    // R12 enable around Shift-DR, then R2 pause/exit walk and tms reset
    tick(1, 0); tick(0, 0);
    chk("R12 oe off in capture", tdo_oe, 0);
    tick(0, 1);
    chk("R12 oe on in shift", tdo_oe, 1);
    tick(1, 0); tick(0, 0); tick(0, 0); tick(1, 0); tick(0, 1); tick(0, 0);
    repeat (5) tick(1, 0);
    tick(0, 0);
    scan_dr(64'h0, 32, d);
    chk("R2 tms reset reloads idcode", d[31:0], ID_EXP);

    for (int op = 5; op <= 6; op++) begin
      load_ir(op[2:0]);
      scan_dr(64'h3C, 8, d);
      chk("R6 unused code bypass", d[7:0], 8'h78);
      chk("R6 unused code modes", {pins_from_scan, outputs_off}, 0);
      chk("R6 unused code strobes", {seen_cap, seen_sh, seen_up}, 0);
    end

    load_ir(3'b000);
    chk("R7 extest pins", pins_from_scan, 1);
    scan_dr(64'h1234, 16, d);
    chk("R7 extest strobes", {seen_cap, seen_sh, seen_up}, 3'b111);

    load_ir(3'b010);
    chk("R8 sample pins", pins_from_scan, 0);
    scan_dr(64'h5A5A, 16, d);
    chk("R8 sample strobes", {seen_cap, seen_sh, seen_up}, 3'b111);

    load_ir(3'b011);
    chk("R9 clamp pins", pins_from_scan, 1);
    scan_dr(64'h96, 8, d);
    chk("R9 clamp bypass", d[7:0], 8'h2C);
    chk("R9 clamp strobes", {seen_cap, seen_sh, seen_up}, 0);

    load_ir(3'b100);
    chk("R10 highz off", outputs_off, 1);
    chk("R10 highz pins", pins_from_scan, 0);

    shift_ir(3'b000, c);
    chk("R11 off held before update", outputs_off, 1);
    chk("R11 pins held before update", pins_from_scan, 0);
    finish_ir();
    chk("R11 off after update", outputs_off, 0);
    chk("R11 pins after update", pins_from_scan, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule